// File: doc/BRIEF.md
# Vector Feature-Support Trap Checker

This block sits at the issue point of a core that accepts vector-prefixed instructions but may implement only part of the vector feature set. For every command it decides either that the instruction may run in hardware or that it must raise an illegal-instruction trap, so that software can emulate the missing feature. The decision depends on three things: a capability mask fixed at elaboration, the fields of the prefix, and the live contents of the vector context register. The same opcode can therefore run or trap depending on what software last wrote into that context.

The block keeps the vector context register itself. This register holds the vector length, the element-width override, the sub-vector length, the mode bits and three reserved bits. Software can write it through one implemented special-purpose register number. It can also change the length through a reduced form of the length-setting instruction, which only clamps and records the length. Every other special-purpose register number traps on both read and write. Each outcome appears on registered outputs one cycle after the command. A trap carries the program-interrupt vector 0x700 and blocks any state change from the command that caused it.

Top module: `vtrap_check`

## Requirements
- R1: After reset, `exec_ok_o` and `trap_o` are 0, `trap_vector_o` is 0 and `vstate_o` is 16'h0001. The context layout is: length in bits [6:0], element width in [8:7], sub-vector length in [10:9], mode in [12:11], reserved in [15:13].
- R2: A prefixed-op command (`issue_cmd_i` = 0) that requests only supported features raises `exec_ok_o` for one cycle, in the cycle after issue, with `trap_o` low.
- R3: A prefixed-op command traps when the context length is greater than 1 and capability bit 0 (multi-element vectors) is clear.
- R4: A prefixed-op command traps when any context field other than length is nonzero and the matching capability is clear. Element width is bit 1, sub-vector length is bit 2 and mode is bit 3. Nonzero reserved bits always trap.
- R5: A prefix element-width override (`pfx_ew_i` nonzero) traps when capability bit 1 is clear. Predication (`pfx_pred_i` = 1) executes when capability bit 4 is set and traps when it is clear.
- R6: A prefixed-op command whose major opcode equals the packed-SIMD major (default 60) always traps.
- R7: A length-setting command (`issue_cmd_i` = 1) executes when capability bit 5 is set. It writes length = min(`issue_data_i`, MAX_VL) and leaves every other context field unchanged. With bit 5 clear it traps and leaves the context unchanged.
- R8: A special-register read (`issue_cmd_i` = 2) or write (`issue_cmd_i` = 3) to any number other than the context register (default 720) traps. It leaves `vstate_o` unchanged and returns `rd_data_o` = 0.
- R9: A write to the context register number stores `issue_data_i` as the whole context and executes. A read of it executes and returns the context on `rd_data_o`.
- R10: `trap_vector_o` is 12'h700 exactly when `trap_o` is 1 and 0 otherwise. `exec_ok_o` and `trap_o` are never high together, and both are low in the cycle after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid_i | input | 1 | A command is presented this cycle |
| issue_cmd_i | input | 2 | 0 prefixed op, 1 set length, 2 register read, 3 register write |
| issue_major_i | input | 6 | Major opcode of the prefixed op |
| pfx_ew_i | input | 2 | Prefix element-width override, 0 means none |
| pfx_pred_i | input | 1 | Prefix requests predication |
| spr_num_i | input | 10 | Special-purpose register number |
| issue_data_i | input | 16 | Requested length or register write data |
| exec_ok_o | output | 1 | Command may execute in hardware |
| trap_o | output | 1 | Illegal-instruction trap request |
| trap_vector_o | output | 12 | Interrupt vector offset of the trap |
| rd_data_o | output | 16 | Register read data |
| vstate_o | output | 16 | Current vector context |

## Verification
Every result (`exec_ok_o`, `trap_o`, `trap_vector_o`, `rd_data_o`) is due in the single cycle after the command's issue edge, because the decision logic feeds one register stage. A context update shows on `vstate_o` after that same edge and governs the next command. Each scenario task drives its command at a falling edge, waits for the following rising edge and samples a short time after it. It then drops `issue_valid_i` before the next edge, so every sample belongs to exactly one command. The bench keeps its own copy of the context and derives each expected length, trap and read value from the requirements.

// File: rtl/vtrap_pkg.sv
package vtrap_pkg;

    localparam int STATE_W = 16;
    localparam int VL_W    = 7;
    localparam int CAP_W   = 6;

    // capability bit positions
    localparam int CAP_VEC   = 0;
    localparam int CAP_ELW   = 1;
    localparam int CAP_SUBVL = 2;
    localparam int CAP_MODE  = 3;
    localparam int CAP_PRED  = 4;
    localparam int CAP_SETVL = 5;

    localparam logic [11:0] TRAP_VEC = 12'h700;

    typedef enum logic [1:0] {
        CMD_OP    = 2'd0,
        CMD_SETVL = 2'd1,
        CMD_SPRRD = 2'd2,
        CMD_SPRWR = 2'd3
    } cmd_e;

    typedef struct packed {
        logic [2:0]      rsvd;
        logic [1:0]      mode;
        logic [1:0]      subvl;
        logic [1:0]      elw;
        logic [VL_W-1:0] vl;
    } vstate_t;

    localparam vstate_t VSTATE_RST = '{rsvd: '0, mode: '0, subvl: '0, elw: '0, vl: VL_W'(1)};

    typedef struct packed {
        logic              exec;
        logic              trap;
        logic [STATE_W-1:0] rd;
        vstate_t           st;
    } regs_t;

endpackage

// File: rtl/vtrap_spr_map.sv
module vtrap_spr_map #(
    parameter int SPR_W      = 10,
    parameter int VSTATE_NUM = 720
) (
    input  logic [SPR_W-1:0] spr_i,
    output logic             hit_o
);
    always_comb hit_o = (spr_i == SPR_W'(VSTATE_NUM));
endmodule

// File: rtl/vtrap_feat_check.sv
module vtrap_feat_check
    import vtrap_pkg::*;
#(
    parameter logic [CAP_W-1:0] CAPS       = 6'b110000,
    parameter logic [5:0]       SIMD_MAJOR = 6'd60
) (
    input  vstate_t    st_i,
    input  logic [5:0] major_i,
    input  logic [1:0] ew_i,
    input  logic       pred_i,
    output logic       trap_o
);
    logic st_bad, pfx_bad, op_bad;

    always_comb begin
        st_bad  = (st_i.rsvd != '0)
                | (!CAPS[CAP_VEC]   && (st_i.vl > VL_W'(1)))
                | (!CAPS[CAP_ELW]   && (st_i.elw   != '0))
                | (!CAPS[CAP_SUBVL] && (st_i.subvl != '0))
                | (!CAPS[CAP_MODE]  && (st_i.mode  != '0));
        pfx_bad = (!CAPS[CAP_ELW]  && (ew_i != '0))
                | (!CAPS[CAP_PRED] && pred_i);
        op_bad  = (major_i == SIMD_MAJOR);
        trap_o  = st_bad | pfx_bad | op_bad;
    end
endmodule

// File: rtl/vtrap_setvl.sv
module vtrap_setvl
    import vtrap_pkg::*;
#(
    parameter int MAX_VL = 64
) (
    input  vstate_t            st_i,
    input  logic [STATE_W-1:0] req_i,
    output vstate_t            st_o
);
    always_comb begin
        st_o = st_i;
        if (req_i > STATE_W'(MAX_VL))
            st_o.vl = VL_W'(MAX_VL);
        else
            st_o.vl = req_i[VL_W-1:0];
    end
endmodule

// File: rtl/vtrap_check.sv
module vtrap_check
    import vtrap_pkg::*;
#(
    parameter logic [CAP_W-1:0] CAPS       = 6'b110000,
    parameter logic [5:0]       SIMD_MAJOR = 6'd60,
    parameter int               MAX_VL     = 64,
    parameter int               SPR_W      = 10,
    parameter int               VSTATE_NUM = 720
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid_i,
    input  logic [1:0]         issue_cmd_i,
    input  logic [5:0]         issue_major_i,
    input  logic [1:0]         pfx_ew_i,
    input  logic               pfx_pred_i,
    input  logic [SPR_W-1:0]   spr_num_i,
    input  logic [STATE_W-1:0] issue_data_i,
    output logic               exec_ok_o,
    output logic               trap_o,
    output logic [11:0]        trap_vector_o,
    output logic [STATE_W-1:0] rd_data_o,
    output logic [STATE_W-1:0] vstate_o
);
    regs_t   r_q, r_d;
    logic    spr_hit, feat_trap;
    vstate_t setvl_st;
    cmd_e    cmd;

    assign cmd = cmd_e'(issue_cmd_i);

    vtrap_spr_map #(.SPR_W(SPR_W), .VSTATE_NUM(VSTATE_NUM)) u_spr (
        .spr_i (spr_num_i),
        .hit_o (spr_hit)
    );

    vtrap_feat_check #(.CAPS(CAPS), .SIMD_MAJOR(SIMD_MAJOR)) u_feat (
        .st_i    (r_q.st),
        .major_i (issue_major_i),
        .ew_i    (pfx_ew_i),
        .pred_i  (pfx_pred_i),
        .trap_o  (feat_trap)
    );

    vtrap_setvl #(.MAX_VL(MAX_VL)) u_setvl (
        .st_i  (r_q.st),
        .req_i (issue_data_i),
        .st_o  (setvl_st)
    );

    always_comb begin
        r_d      = r_q;
        r_d.exec = 1'b0;
        r_d.trap = 1'b0;
        r_d.rd   = '0;
        if (issue_valid_i) begin
            unique case (cmd)
                CMD_OP: begin
                    r_d.trap = feat_trap;
                    r_d.exec = !feat_trap;
                end
                CMD_SETVL: begin
                    if (CAPS[CAP_SETVL]) begin
                        r_d.exec = 1'b1;
                        r_d.st   = setvl_st;
                    end else begin
                        r_d.trap = 1'b1;
                    end
                end
                CMD_SPRRD: begin
                    r_d.exec = spr_hit;
                    r_d.trap = !spr_hit;
                    if (spr_hit) r_d.rd = r_q.st;
                end
                CMD_SPRWR: begin
                    r_d.exec = spr_hit;
                    r_d.trap = !spr_hit;
                    if (spr_hit) r_d.st = vstate_t'(issue_data_i);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.exec <= 1'b0;
            r_q.trap <= 1'b0;
            r_q.rd   <= '0;
            r_q.st   <= VSTATE_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign exec_ok_o     = r_q.exec;
    assign trap_o        = r_q.trap;
    assign trap_vector_o = r_q.trap ? TRAP_VEC : 12'h000;
    assign rd_data_o     = r_q.rd;
    assign vstate_o      = r_q.st;

endmodule

// File: rtl/vtrap_check_sva.sv
module vtrap_check_sva
    import vtrap_pkg::*;
#(
    parameter logic [CAP_W-1:0] CAPS       = 6'b110000,
    parameter logic [5:0]       SIMD_MAJOR = 6'd60,
    parameter int               MAX_VL     = 64,
    parameter int               SPR_W      = 10,
    parameter int               VSTATE_NUM = 720
) (
    input logic               clk,
    input logic               rst_n,
    input logic               issue_valid_i,
    input logic [1:0]         issue_cmd_i,
    input logic [5:0]         issue_major_i,
    input logic [SPR_W-1:0]   spr_num_i,
    input logic               exec_ok_o,
    input logic               trap_o,
    input logic [11:0]        trap_vector_o,
    input logic [STATE_W-1:0] vstate_o
);
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_ok_o && trap_o));

    p_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (trap_vector_o == 12'h700));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid_i |=> (!exec_ok_o && !trap_o));

    p_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_i |=> (exec_ok_o || trap_o));

    p_simd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && issue_cmd_i == 2'd0 && issue_major_i == SIMD_MAJOR) |=> trap_o);

    p_badspr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && issue_cmd_i == 2'd3 && spr_num_i != SPR_W'(VSTATE_NUM))
        |=> (trap_o && $stable(vstate_o)));

    p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && issue_cmd_i == 2'd1 && CAPS[CAP_SETVL])
        |=> (vstate_o[VL_W-1:0] <= VL_W'(MAX_VL)));
endmodule

bind vtrap_check vtrap_check_sva #(
    .CAPS(CAPS), .SIMD_MAJOR(SIMD_MAJOR), .MAX_VL(MAX_VL),
    .SPR_W(SPR_W), .VSTATE_NUM(VSTATE_NUM)
) u_sva (
    .clk(clk), .rst_n(rst_n), .issue_valid_i(issue_valid_i),
    .issue_cmd_i(issue_cmd_i), .issue_major_i(issue_major_i),
    .spr_num_i(spr_num_i), .exec_ok_o(exec_ok_o), .trap_o(trap_o),
    .trap_vector_o(trap_vector_o), .vstate_o(vstate_o)
);

// File: tb/vtrap_check_test.sv
`timescale 1ns/1ps
module vtrap_check_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid_i = 1'b0;
    logic [1:0]  issue_cmd_i = '0;
    logic [5:0]  issue_major_i = '0;
    logic [1:0]  pfx_ew_i = '0;
    logic        pfx_pred_i = 1'b0;
    logic [9:0]  spr_num_i = '0;
    logic [15:0] issue_data_i = '0;
    logic        exec_ok_o, trap_o;
    logic [11:0] trap_vector_o;
    logic [15:0] rd_data_o, vstate_o;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model_st;

    localparam int ADDI = 14;
    localparam int CTX  = 720;

    always #5 clk = ~clk;

    vtrap_check uut (
        .clk(clk), .rst_n(rst_n), .issue_valid_i(issue_valid_i),
        .issue_cmd_i(issue_cmd_i), .issue_major_i(issue_major_i),
        .pfx_ew_i(pfx_ew_i), .pfx_pred_i(pfx_pred_i), .spr_num_i(spr_num_i),
        .issue_data_i(issue_data_i), .exec_ok_o(exec_ok_o), .trap_o(trap_o),
        .trap_vector_o(trap_vector_o), .rd_data_o(rd_data_o), .vstate_o(vstate_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // drive at falling edge, sample just after the next rising edge
    task automatic issue(input logic [1:0] cmd, input logic [5:0] major, input logic [1:0] ew,
                         input logic pred, input logic [9:0] spr, input logic [15:0] data);
        @(negedge clk);
        issue_valid_i = 1'b1; issue_cmd_i = cmd; issue_major_i = major;
        pfx_ew_i = ew; pfx_pred_i = pred; spr_num_i = spr; issue_data_i = data;
        @(posedge clk);
        #2;
        issue_valid_i = 1'b0;
    endtask

    task automatic expect_outcome(input string req, input logic trap);
        chk({req, " exec"}, exec_ok_o, !trap);
        chk({req, " trap"}, trap_o, trap);
        chk({req, " vector"}, trap_vector_o, trap ? 12'h700 : 12'h000);
    endtask

    task automatic t_reset();
        chk("R1 exec", exec_ok_o, 0);
        chk("R1 trap", trap_o, 0);
        chk("R1 vector", trap_vector_o, 0);
        chk("R1 state", vstate_o, 16'h0001);
    endtask

    task automatic t_scalar_ok();
        issue(2'd0, ADDI, 2'd0, 1'b0, '0, '0);
        expect_outcome("R2 plain op", 1'b0);
        issue(2'd0, ADDI, 2'd0, 1'b1, '0, '0);
        expect_outcome("R5 predicated op", 1'b0);
    endtask

    task automatic t_length();
        issue(2'd1, '0, '0, 1'b0, '0, 16'd4);
        model_st[6:0] = 7'd4;
        expect_outcome("R7 setvl 4", 1'b0);
        chk("R7 state after setvl 4", vstate_o, model_st);
        issue(2'd0, ADDI, 2'd0, 1'b0, '0, '0);
        expect_outcome("R3 op with length 4", 1'b1);
        issue(2'd1, '0, '0, 1'b0, '0, 16'd200);
        model_st[6:0] = 7'd64;
        chk("R7 clamp", vstate_o, model_st);
        issue(2'd1, '0, '0, 1'b0, '0, 16'd1);
        model_st[6:0] = 7'd1;
        chk("R7 setvl 1", vstate_o, model_st);
        issue(2'd0, ADDI, 2'd0, 1'b0, '0, '0);
        expect_outcome("R3 op with length 1", 1'b0);
    endtask

    task automatic t_prefix_ew();
        issue(2'd0, ADDI, 2'd1, 1'b0, '0, '0);
        expect_outcome("R5 ew override", 1'b1);
        issue(2'd0, ADDI, 2'd3, 1'b1, '0, '0);
        expect_outcome("R5 ew override with pred", 1'b1);
    endtask

    task automatic t_simd();
        issue(2'd0, 6'd60, 2'd0, 1'b0, '0, '0);
        expect_outcome("R6 packed-SIMD major", 1'b1);
        issue(2'd0, 6'd59, 2'd0, 1'b0, '0, '0);
        expect_outcome("R6 neighbour major", 1'b0);
    endtask

    task automatic ctx_then_op(input string req, input logic [15:0] val, input logic trap);
        issue(2'd3, '0, '0, 1'b0, CTX, val);
        model_st = val;
        expect_outcome({req, " write"}, 1'b0);
        chk({req, " state"}, vstate_o, model_st);
        issue(2'd0, ADDI, 2'd0, 1'b0, '0, '0);
        expect_outcome({req, " op"}, trap);
    endtask

    task automatic t_context();
        ctx_then_op("R9 R4 elw field", 16'h0081, 1'b1);
        issue(2'd2, '0, '0, 1'b0, CTX, '0);
        expect_outcome("R9 read", 1'b0);
        chk("R9 read data", rd_data_o, 16'h0081);
        ctx_then_op("R4 subvl field", 16'h0201, 1'b1);
        ctx_then_op("R4 mode field", 16'h0801, 1'b1);
        ctx_then_op("R4 reserved bit", 16'h2001, 1'b1);
        ctx_then_op("R9 back to scalar", 16'h0001, 1'b0);
        issue(2'd1, '0, '0, 1'b0, '0, 16'd0);
        issue(2'd3, '0, '0, 1'b0, CTX, 16'h0081);
        issue(2'd1, '0, '0, 1'b0, '0, 16'd9);
        model_st = 16'h0089;
        chk("R7 keeps other fields", vstate_o, model_st);
        issue(2'd3, '0, '0, 1'b0, CTX, 16'h0001);
        model_st = 16'h0001;
    endtask

    task automatic t_bad_spr();
        issue(2'd3, '0, '0, 1'b0, 10'd721, 16'h0044);
        expect_outcome("R8 write other number", 1'b1);
        chk("R8 state unchanged", vstate_o, model_st);
        issue(2'd2, '0, '0, 1'b0, 10'd0, '0);
        expect_outcome("R8 read other number", 1'b1);
        chk("R8 read data zero", rd_data_o, 16'h0000);
        issue(2'd2, '0, '0, 1'b0, 10'd1023, '0);
        expect_outcome("R8 read reserved number", 1'b1);
    endtask

    task automatic t_idle();
        @(negedge clk);
        @(posedge clk);
        #2;
        chk("R10 idle exec", exec_ok_o, 0);
        chk("R10 idle trap", trap_o, 0);
        chk("R10 idle vector", trap_vector_o, 0);
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        model_st = 16'h0001;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        t_reset();
        t_scalar_ok();
        t_length();
        t_prefix_ew();
        t_simd();
        t_context();
        t_bad_spr();
        t_idle();
        summary();
    end
endmodule